// File: doc/BRIEF.md
# Sequential-Read I2C Boot Image Target

This block is an I2C target that takes the place of a small serial configuration memory. A USB host controller reads it at power-up to fetch its identity bytes. The block watches the open-drain SCL and SDA lines through a synchroniser. It answers one fixed 7-bit device address. It streams bytes in order from a 16-byte image, and a static profile-select strap picks which image is used. Each image carries a boot marker, vendor, product and device identifiers, and a configuration byte. All remaining bytes read as erased (0xFF).

The target supports sequential reads only. The image is read-only. A word-address byte sent by the host is acknowledged but has no effect, so a random-access read carries on from the current read pointer. Before each byte it sends, the block holds SCL low for a fixed, parameterised number of clocks, and releases it once the first data bit is on SDA. Outputs are active-high pull-down enables for the two open-drain pads.

Top module: `i2c_boot_rom`

## Requirements
- R1: The block acknowledges (drives SDA low in the ninth bit) an address byte whose upper seven bits equal DEV_ADDR (default 0x50), for both read (bit 0 = 1) and write (bit 0 = 0).
- R2: For any other address, the block gives no acknowledge, does not drive SDA and does not hold SCL until the next START.
- R3: Read data is sent MSB first, one image byte per byte slot, starting at the current read pointer.
- R4: Image layout per profile: byte 0 = 0xC0, bytes 1/2 = vendor ID low/high, bytes 3/4 = product ID low/high, bytes 5/6 = device ID low/high, byte 7 = configuration byte, bytes 8 to 15 = 0xFF. profile_sel chooses the profile. A value of NUM_PROF or above selects profile 0.
- R5: The read pointer wraps from byte 15 to byte 0 during a sequential read.
- R6: Write data bytes are acknowledged and discarded. A later read shows the image unchanged.
- R7: A word-address byte written before a repeated-START read is ignored, so the read begins at the current pointer (byte 0 after a STOP).
- R8: A START that follows a STOP (or reset) sets the pointer to 0. A repeated START keeps the pointer.
- R9: Every byte sent advances the pointer. A host ACK makes the block send the next byte. After a host NACK, the block releases SDA and drives neither line until the next START or STOP.
- R10: Before each read byte, SCL is held low for exactly STRETCH_CYC+1 clocks. SDA takes its first bit one clock before SCL is released. The stretch must be below 10 µs, which is checked at elaboration from CLK_HZ.
- R11: After reset, neither line is driven and the pointer is 0.
- R12: A STOP in any state ends the transfer and releases both lines. SDA driven by the block changes only while synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| profile_sel | input | PROF_W | Static choice of identity image |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or a zero data bit) |

## Verification
The bench builds the block with STRETCH_CYC = 6 and keeps the default three profiles, the 0x50 address and the two-stage synchroniser. The short stretch lets a single run make reads longer than 16 bytes to reach the wrap, and clock through a held-low window many times while measuring its exact length. Two bits of profile_sel also reach the unused code 3, which shows the fallback to profile 0.

// File: rtl/i2c_boot_pkg.sv
`timescale 1ns / 1ps
package i2c_boot_pkg;

   // Byte-engine states of the boot image target
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_STRETCH,
      ST_RELEASE,
      ST_RD,
      ST_RD_ACK,
      ST_RD_NEXT,
      ST_PARK
   } tgt_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns / 1ps
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   // Idle bus is high on both lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   // Bus conditions: SDA edge while SCL stays high
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_boot_image.sv
`timescale 1ns / 1ps
module i2c_boot_image #(
   parameter int                       NUM_PROF = 3,
   parameter int                       PROF_W   = 2,
   parameter int                       DEPTH    = 16,
   parameter int                       ADDR_W   = 4,
   parameter logic [NUM_PROF*16-1:0]   VID_SET  = '0,
   parameter logic [NUM_PROF*16-1:0]   PID_SET  = '0,
   parameter logic [NUM_PROF*16-1:0]   DID_SET  = '0,
   parameter logic [NUM_PROF*8-1:0]    CFG_SET  = '0
) (
   input  logic [PROF_W-1:0] prof_sel,
   input  logic [ADDR_W-1:0] idx,
   output logic [7:0]        data
);

   if (DEPTH < 8) begin : g_bad_depth
      $error("i2c_boot_image: DEPTH must hold the 8-byte header");
   end

   function automatic logic [7:0] img_byte(input int p, input logic [ADDR_W-1:0] i);
      logic [15:0] v;
      logic [15:0] pd;
      logic [15:0] dv;
      logic [7:0]  c;
      v  = VID_SET[p*16 +: 16];
      pd = PID_SET[p*16 +: 16];
      dv = DID_SET[p*16 +: 16];
      c  = CFG_SET[p*8 +: 8];
      case (int'(i))
         0:       img_byte = 8'hC0;
         1:       img_byte = v[7:0];
         2:       img_byte = v[15:8];
         3:       img_byte = pd[7:0];
         4:       img_byte = pd[15:8];
         5:       img_byte = dv[7:0];
         6:       img_byte = dv[15:8];
         7:       img_byte = c;
         default: img_byte = 8'hFF;
      endcase
   endfunction

   logic [7:0] per_prof [NUM_PROF];

   for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
      assign per_prof[p] = img_byte(p, idx);
   end

   // Out-of-range profile codes fall back to profile 0
   always_comb begin
      data = per_prof[0];
      for (int k = 1; k < NUM_PROF; k++) begin
         if (int'(prof_sel) == k) data = per_prof[k];
      end
   end

endmodule

// File: rtl/i2c_stretch_timer.sv
`timescale 1ns / 1ps
module i2c_stretch_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("i2c_stretch_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!done) cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == CNT_W'(CYCLES - 1));

   // R10
   // timer_run_chk
   timer_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !done) |=> (cnt != '0 || !run));

endmodule

// File: rtl/i2c_boot_rom.sv
`timescale 1ns / 1ps
module i2c_boot_rom
   import i2c_boot_pkg::*;
#(
   parameter logic [6:0]               DEV_ADDR    = 7'h50,
   parameter int                       NUM_PROF    = 3,
   parameter int                       PROF_W      = 2,
   parameter int                       IMG_DEPTH   = 16,
   parameter int                       SYNC_STAGES = 2,
   parameter int                       STRETCH_CYC = 64,
   parameter int                       CLK_HZ      = 200_000_000,
   parameter logic [NUM_PROF*16-1:0]   VID_SET     = {16'h0925, 16'h1209, 16'h04B4},
   parameter logic [NUM_PROF*16-1:0]   PID_SET     = {16'h3881, 16'h0001, 16'h8613},
   parameter logic [NUM_PROF*16-1:0]   DID_SET     = {16'h0130, 16'h0002, 16'hA001},
   parameter logic [NUM_PROF*8-1:0]    CFG_SET     = {8'h40, 8'h01, 8'h00}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [PROF_W-1:0] profile_sel,
   output logic              scl_oe,
   output logic              sda_oe
);

   localparam int PTR_W = $clog2(IMG_DEPTH);
   localparam longint unsigned STRETCH_NS =
      (longint'(STRETCH_CYC) * 64'd1_000_000_000) / longint'(CLK_HZ);
   localparam int LEN_W = $clog2(STRETCH_CYC + 4);

   // Elaboration-time parameter checks
   if (IMG_DEPTH < 8 || (IMG_DEPTH & (IMG_DEPTH - 1)) != 0) begin : g_bad_img
      $error("i2c_boot_rom: IMG_DEPTH must be a power of two, at least 8");
   end
   if (STRETCH_NS >= 64'd10_000) begin : g_bad_stretch
      $error("i2c_boot_rom: stretch window must stay below 10 us");
   end
   if (CLK_HZ < 20 * 400_000) begin : g_bad_clk
      $error("i2c_boot_rom: clock too slow for 400 kHz bus");
   end
   if (NUM_PROF < 1 || NUM_PROF > (1 << PROF_W)) begin : g_bad_prof
      $error("i2c_boot_rom: NUM_PROF does not fit PROF_W");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_c  (start_c),
      .stop_c   (stop_c)
   );

   tgt_state_e        state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] tx;
   logic [PTR_W-1:0]  ptr;
   logic              rw_q;
   logic              stopped_q;
   logic [7:0]        img_data;
   logic              tmr_done;

   i2c_boot_image #(
      .NUM_PROF (NUM_PROF),
      .PROF_W   (PROF_W),
      .DEPTH    (IMG_DEPTH),
      .ADDR_W   (PTR_W),
      .VID_SET  (VID_SET),
      .PID_SET  (PID_SET),
      .DID_SET  (DID_SET),
      .CFG_SET  (CFG_SET)
   ) u_image (
      .prof_sel (profile_sel),
      .idx      (ptr),
      .data     (img_data)
   );

   i2c_stretch_timer #(.CYCLES(STRETCH_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_STRETCH),
      .done  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         tx        <= '0;
         ptr       <= '0;
         rw_q      <= 1'b0;
         stopped_q <= 1'b1;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (stop_c) begin
         state     <= ST_IDLE;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
         stopped_q <= 1'b1;
      end else if (start_c) begin
         state     <= ST_ADDR;
         bit_cnt   <= '0;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
         stopped_q <= 1'b0;
         if (stopped_q) ptr <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_PARK: ;
            ST_ADDR: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  if (shreg[7:1] == DEV_ADDR) begin
                     sda_oe <= 1'b1;
                     rw_q   <= shreg[0];
                     state  <= ST_ADDR_ACK;
                  end else begin
                     state  <= ST_PARK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
                  if (rw_q) begin
                     scl_oe <= 1'b1;
                     state  <= ST_STRETCH;
                  end else begin
                     state  <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               // Bytes are shifted in only to count them; contents are dropped
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  sda_oe <= 1'b1;
                  state  <= ST_WR_ACK;
               end
            end
            ST_WR_ACK: begin
               if (scl_fall) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
                  state   <= ST_WR;
               end
            end
            ST_STRETCH: begin
               if (tmr_done) begin
                  tx     <= img_data;
                  sda_oe <= ~img_data[7];
                  state  <= ST_RELEASE;
               end
            end
            ST_RELEASE: begin
               scl_oe  <= 1'b0;
               bit_cnt <= '0;
               state   <= ST_RD;
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 1'b1;
                     state  <= ST_RD_ACK;
                  end else begin
                     tx      <= {tx[6:0], 1'b0};
                     sda_oe  <= ~tx[6];
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) state <= sda_s ? ST_PARK : ST_RD_NEXT;
            end
            ST_RD_NEXT: begin
               if (scl_fall) begin
                  scl_oe <= 1'b1;
                  state  <= ST_STRETCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Checker state: length of the current SCL hold
   logic [LEN_W-1:0] hold_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_len <= '0;
      else if (scl_oe) hold_len <= hold_len + 1'b1;
      else             hold_len <= '0;
   end

   // R10
   // stretch_len_chk
   stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> (int'(hold_len) < STRETCH_CYC + 1));

   // R12
   // sda_scl_low_chk
   sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   // R5
   // ptr_step_chk
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> ((ptr == PTR_W'($past(ptr) + 1'b1)) || (ptr == '0)));

   // R9
   // park_quiet_chk
   park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PARK) |-> (!sda_oe && !scl_oe));

   // R8
   // restart_ptr_chk
   restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_c && !stop_c && stopped_q) |=> (ptr == '0));

endmodule

// File: tb/i2c_boot_rom_tb.sv
`timescale 1ns / 1ps
module i2c_boot_rom_tb_top;

   localparam int H       = 8;
   localparam int STRETCH = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] profile_sel = 2'd0;
   logic       scl_oe, sda_oe;
   wire        scl_bus = scl_m & ~scl_oe;
   wire        sda_bus = sda_m & ~sda_oe;

   always #2.5 clk = ~clk;

   i2c_boot_rom #(.STRETCH_CYC(STRETCH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_in      (scl_bus),
      .sda_in      (sda_bus),
      .profile_sel (profile_sel),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] rd_buf [0:31];

   // Stretch length monitor
   int st_run = 0;
   int st_min = 1000000;
   int st_max = 0;
   always @(negedge clk) begin
      if (scl_oe) st_run++;
      else if (st_run != 0) begin
         if (st_run < st_min) st_min = st_run;
         if (st_run > st_max) st_max = st_run;
         st_run = 0;
      end
   end

   typedef struct packed {
      logic [1:0] prof;
      logic [3:0] idx;
      logic [7:0] exp;
   } vec_t;

   localparam vec_t VEC [12] = '{
      '{2'd0, 4'd0,  8'hC0},
      '{2'd0, 4'd1,  8'hB4},
      '{2'd0, 4'd2,  8'h04},
      '{2'd0, 4'd4,  8'h86},
      '{2'd1, 4'd3,  8'h01},
      '{2'd1, 4'd5,  8'h02},
      '{2'd2, 4'd2,  8'h09},
      '{2'd2, 4'd3,  8'h81},
      '{2'd2, 4'd7,  8'h40},
      '{2'd2, 4'd9,  8'hFF},
      '{2'd3, 4'd1,  8'hB4},
      '{2'd1, 4'd15, 8'hFF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_hi;
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; wait_scl_hi; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; wait_scl_hi; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; tick(H);
      scl_m = 1'b1; wait_scl_hi; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; wait_scl_hi; tick(H / 2);
      b = sda_bus; tick(H / 2);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic write_byte(input logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(a);
      ack = !a;
   endtask

   task automatic read_byte(input logic ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      bit_out(!ack);
   endtask

   task automatic do_read(input logic [1:0] prof, input int n, output logic ack);
      profile_sel = prof;
      bus_start;
      write_byte(8'hA1, ack);
      for (int k = 0; k < n; k++) read_byte(k != n - 1, rd_buf[k]);
      bus_stop;
      tick(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] v;
      tick(5);
      // R11 reset state
      chk("R11 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
      chk("R11 scl_oe in reset", {31'd0, scl_oe}, 32'd0);
      rst_n = 1'b1;
      tick(5);
      do_read(2'd0, 1, a);
      chk("R11 first byte after reset", {24'd0, rd_buf[0]}, 32'hC0);
      chk("R1 read address ack", {31'd0, a}, 32'd1);

      // Table walk: R3/R4 image contents and order
      foreach (VEC[i]) begin
         do_read(VEC[i].prof, int'(VEC[i].idx) + 1, a);
         chk($sformatf("R4 R3 vec%0d", i), {24'd0, rd_buf[VEC[i].idx]}, {24'd0, VEC[i].exp});
      end

      // R10 stretch length
      st_min = 1000000; st_max = 0;
      do_read(2'd1, 3, a);
      chk("R10 min stretch", st_min, STRETCH + 1);
      chk("R10 max stretch", st_max, STRETCH + 1);

      // R5 wrap past byte 15
      do_read(2'd0, 18, a);
      chk("R5 wrap byte 16", {24'd0, rd_buf[16]}, 32'hC0);
      chk("R5 wrap byte 17", {24'd0, rd_buf[17]}, 32'hB4);

      // R2 foreign write address
      bus_start;
      st_min = 1000000; st_max = 0;
      write_byte(8'hA2, a);
      chk("R2 no ack on 0x51 write", {31'd0, a}, 32'd0);
      bus_stop;
      // R2 foreign read address: lines stay released
      bus_start;
      write_byte(8'h47, a);
      chk("R2 no ack on 0x23 read", {31'd0, a}, 32'd0);
      read_byte(1'b0, v);
      chk("R2 no data driven", {24'd0, v}, 32'hFF);
      chk("R2 no stretch", st_max, 0);
      bus_stop;

      // R6 writes acknowledged and discarded
      profile_sel = 2'd0;
      bus_start;
      write_byte(8'hA0, a);
      chk("R1 write address ack", {31'd0, a}, 32'd1);
      write_byte(8'h00, a);
      chk("R6 data byte ack", {31'd0, a}, 32'd1);
      write_byte(8'h55, a);
      chk("R6 second data byte ack", {31'd0, a}, 32'd1);
      bus_stop;
      do_read(2'd0, 2, a);
      chk("R6 image byte 0 unchanged", {24'd0, rd_buf[0]}, 32'hC0);
      chk("R6 image byte 1 unchanged", {24'd0, rd_buf[1]}, 32'hB4);

      // R7 word-address byte ignored on random read
      bus_start;
      write_byte(8'hA0, a);
      write_byte(8'h05, a);
      chk("R7 word address ack", {31'd0, a}, 32'd1);
      bus_start;
      write_byte(8'hA1, a);
      read_byte(1'b0, v);
      chk("R7 random read starts at 0", {24'd0, v}, 32'hC0);
      bus_stop;

      // R8/R9 repeated start keeps pointer; each byte advances it
      bus_start;
      write_byte(8'hA1, a);
      read_byte(1'b1, v);
      read_byte(1'b1, v);
      read_byte(1'b0, v);
      chk("R9 third byte", {24'd0, v}, 32'h04);
      bus_start;
      write_byte(8'hA1, a);
      read_byte(1'b0, v);
      chk("R8 repeated start continues", {24'd0, v}, 32'h13);
      // R9 after NACK the block is quiet
      tick(H);
      chk("R9 sda released after nack", {31'd0, sda_oe}, 32'd0);
      st_min = 1000000; st_max = 0;
      read_byte(1'b0, v);
      chk("R9 no data after nack", {24'd0, v}, 32'hFF);
      chk("R9 no stretch after nack", st_max, 0);
      bus_stop;

      // R12 stop mid-byte ends the write
      bus_start;
      write_byte(8'hA0, a);
      bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      bus_stop;
      tick(4);
      chk("R12 sda released after stop", {31'd0, sda_oe}, 32'd0);
      chk("R12 scl released after stop", {31'd0, scl_oe}, 32'd0);
      do_read(2'd2, 2, a);
      chk("R12 R8 read after stop", {24'd0, rd_buf[1]}, 32'h25);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule